// File: doc/BRIEF.md
# Saturating Fractional Multiplier

This block multiplies two signed two's-complement fractions held in 32-bit Q1.31 form. The raw integer product is a 64-bit Q2.62 value. The block shifts that product left by one place to get a Q1.63 fraction. It then returns either that full double-length result or a single 32-bit Q1.31 result rounded to nearest. The choice is made per operation by a length select.

The 64-bit product normally carries two identical sign bits at the top. The one exception is minus one times minus one, where the product is +1. The block checks this before shifting. In that case it outputs the largest positive fraction, because the shift alone would turn +1 into -1.

A symmetric-range option maps an operand of 0x80000000 to 0x80000001, so the exceptional pair cannot occur. Every result carries a saturation bit. A sticky overflow flag collects these bits until it is cleared. Operands enter and results leave through valid/ready handshakes. The pipeline has two register stages.

Top module: `fracmul_top`

## Requirements
- R1: With in_len=0 (double length), {out_hi,out_lo} equals the 64-bit two's-complement product of in_a and in_b shifted left by one bit, whenever bits 63 and 62 of the unshifted product are equal.
- R2: When bits 63 and 62 of the unshifted product differ (only 0x80000000 times 0x80000000), the result is clamped: out_hi=0x7FFFFFFF, and out_lo=0xFFFFFFFF in double-length mode.
- R3: With in_len=1 (single length), out_hi equals bits 63..32 of the shifted product plus bit 31 of it, and out_lo is 0. If that sum would pass 0x7FFFFFFF, out_hi is 0x7FFFFFFF instead.
- R4: out_sat is 1 exactly when the result was clamped by R2 or by the rounding limit of R3.
- R5: sticky_ovf becomes 1 in the cycle a clamped result appears on the output and stays 1 until sticky_clr is high at a clock edge. A set in the same cycle as a clear wins.
- R6: With in_sym=1, an operand equal to 0x80000000 is treated as 0x80000001. Such a result is never clamped and leaves sticky_ovf at 0.
- R7: An operand pair accepted at clock edge k shows out_valid=1 after edge k+1 when the output is not stalled.
- R8: While out_valid=1 and out_ready=0, out_valid, out_hi, out_lo and out_sat stay unchanged. No result is dropped or duplicated.
- R9: Synchronous active-high reset leaves out_valid=0, sticky_ovf=0 and in_ready=1.
- R10: in_ready is 0 when both stages hold data and out_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken this cycle |
| in_a | input | 32 | First Q1.31 operand |
| in_b | input | 32 | Second Q1.31 operand |
| in_sym | input | 1 | 1: map 0x80000000 operands to 0x80000001 |
| in_len | input | 1 | 0: double-length Q1.63 result, 1: rounded Q1.31 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_hi | output | 32 | Upper word, or the rounded single result |
| out_lo | output | 32 | Lower word (0 in single-length mode) |
| out_sat | output | 1 | This result was clamped |
| sticky_clr | input | 1 | Clear the sticky overflow flag |
| sticky_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench targets three corner cases.

The first is minus one times minus one in both length modes. A design that shifts without checking the top two bits would return 0x80000000 there: a full sign inversion with no saturation bit.

The second is the symmetric option on the same operands. A missing operand map would saturate and set the sticky flag instead of returning 0x7FFFFFFE. It also runs rounding on values whose bit 31 is set.

The third is output back-pressure with both stages full. A pipeline that advances regardless of out_ready would change or lose results while stalled. A wrong in_ready would accept a third pair into a full pipe.

The sticky flag is checked across idle cycles and after a clear. A flag that decayed, or ignored its clear, would be caught.

// File: rtl/fracmul_pkg.sv
package fracmul_pkg;

    // Result length selection carried with each operand pair.
    typedef enum logic {
        LEN_DOUBLE = 1'b0,
        LEN_SINGLE = 1'b1
    } len_mode_e;

    // Control fields travelling with the product through the pipe.
    typedef struct packed {
        len_mode_e len;
    } stage_ctrl_t;

    function automatic logic want_single(input stage_ctrl_t c);
        return c.len == LEN_SINGLE;
    endfunction

endpackage

// File: rtl/fracmul_operand_cond.sv
module fracmul_operand_cond #(
    parameter int W = 32
) (
    input  logic         sym_en,
    input  logic [W-1:0] op_in,
    output logic [W-1:0] op_out
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] SYM_NEG  = {1'b1, {(W-2){1'b0}}, 1'b1};

    always_comb begin
        if (sym_en && op_in == MOST_NEG) op_out = SYM_NEG;
        else                             op_out = op_in;
    end

    // R6: the symmetric range never lets the most negative code through
    always_comb begin
        a_r6_no_most_neg: assert (!(sym_en && op_out == MOST_NEG));
    end
endmodule

// File: rtl/fracmul_norm_sat.sv
module fracmul_norm_sat
    import fracmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] raw_prod,
    input  stage_ctrl_t    ctrl,
    output logic [W-1:0]   res_hi,
    output logic [W-1:0]   res_lo,
    output logic           res_sat
);
    localparam int P = 2 * W;
    localparam logic [W-1:0] POS_MAX_W = {1'b0, {(W-1){1'b1}}};
    localparam logic [P-1:0] POS_MAX_P = {1'b0, {(P-1){1'b1}}};

    logic           sign_split;
    logic [P-1:0]   norm;
    logic [W-1:0]   upper;
    logic           round_bit;
    logic           round_ovf;

    always_comb begin
        sign_split = raw_prod[P-1] ^ raw_prod[P-2];
        norm       = sign_split ? POS_MAX_P : {raw_prod[P-2:0], 1'b0};
        upper      = norm[P-1:W];
        round_bit  = norm[W-1];
        round_ovf  = (upper == POS_MAX_W) && round_bit;
    end

    always_comb begin
        if (want_single(ctrl)) begin
            res_hi  = round_ovf ? POS_MAX_W : upper + {{(W-1){1'b0}}, round_bit};
            res_lo  = '0;
            res_sat = sign_split | round_ovf;
        end else begin
            res_hi  = upper;
            res_lo  = norm[W-1:0];
            res_sat = sign_split;
        end
    end

    // R2: a split sign pair always yields the largest positive word on top
    always_comb begin
        a_r2_split_clamps: assert (!sign_split || (res_hi == POS_MAX_W && res_sat));
    end

    // R3: single-length results carry nothing in the low word
    always_comb begin
        a_r3_single_lo_zero: assert (!want_single(ctrl) || res_lo == '0);
    end
endmodule

// File: rtl/fracmul_top.sv
module fracmul_top
    import fracmul_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              in_sym,
    input  logic              in_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_hi,
    output logic [DATA_W-1:0] out_lo,
    output logic              out_sat,
    input  logic              sticky_clr,
    output logic              sticky_ovf
);
    localparam int P      = 2 * DATA_W;
    localparam int N_OPND = 2;

    logic [DATA_W-1:0] opnd_raw  [N_OPND];
    logic [DATA_W-1:0] opnd_cond [N_OPND];

    assign opnd_raw[0] = in_a;
    assign opnd_raw[1] = in_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fracmul_operand_cond #(.W(DATA_W)) cond_i (
            .sym_en (in_sym),
            .op_in  (opnd_raw[g]),
            .op_out (opnd_cond[g])
        );
    end

    // Sign-extended full-width multiply gives the exact Q2.62 product.
    logic signed [P-1:0] ext_a, ext_b, prod;
    always_comb begin
        ext_a = {{DATA_W{opnd_cond[0][DATA_W-1]}}, opnd_cond[0]};
        ext_b = {{DATA_W{opnd_cond[1][DATA_W-1]}}, opnd_cond[1]};
        prod  = ext_a * ext_b;
    end

    // Stage 1: raw product.
    logic        s1_v;
    logic [P-1:0] s1_prod;
    stage_ctrl_t s1_ctrl;

    // Stage 2: normalised, saturated result.
    logic              s2_v;
    logic [DATA_W-1:0] s2_hi, s2_lo;
    logic              s2_sat;

    logic [DATA_W-1:0] ns_hi, ns_lo;
    logic              ns_sat;

    fracmul_norm_sat #(.W(DATA_W)) norm_i (
        .raw_prod (s1_prod),
        .ctrl     (s1_ctrl),
        .res_hi   (ns_hi),
        .res_lo   (ns_lo),
        .res_sat  (ns_sat)
    );

    logic s2_take, s1_take;
    always_comb begin
        s2_take  = s1_v && (!s2_v || out_ready);
        in_ready = !s1_v || s2_take;
        s1_take  = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
        end else if (s1_take) begin
            s1_v <= 1'b1;
        end else if (s2_take) begin
            s1_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (s1_take) begin
            s1_prod     <= prod;
            s1_ctrl.len <= len_mode_e'(in_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v <= 1'b0;
        end else if (s2_take) begin
            s2_v <= 1'b1;
        end else if (out_ready) begin
            s2_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (s2_take) begin
            s2_hi  <= ns_hi;
            s2_lo  <= ns_lo;
            s2_sat <= ns_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     sticky_ovf <= 1'b0;
        else if (s2_take && ns_sat)  sticky_ovf <= 1'b1;
        else if (sticky_clr)         sticky_ovf <= 1'b0;
    end

    assign out_valid = s2_v;
    assign out_hi    = s2_hi;
    assign out_lo    = s2_lo;
    assign out_sat   = s2_sat;

    // R8: a stalled result is held unchanged
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_hi) && $stable(out_lo) && $stable(out_sat));

    // R5: the flag is kept until a clear arrives
    a_r5_sticky_keep: assert property (@(posedge clk) disable iff (rst)
        sticky_ovf && !sticky_clr |=> sticky_ovf);

    // R5: a clamped result entering the output sets the flag
    a_r5_sticky_set: assert property (@(posedge clk) disable iff (rst)
        s2_take && ns_sat |=> sticky_ovf && out_sat && out_valid);

    // R10: no acceptance while both stages are occupied and stalled
    a_r10_full_blocks: assert property (@(posedge clk) disable iff (rst)
        s1_v && out_valid && !out_ready |-> !in_ready);

    // R9: reset empties the pipe and the flag
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid && !sticky_ovf && in_ready);
endmodule

// File: tb/fracmul_top_tb_top.sv
module fracmul_top_tb_top;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_a = '0, in_b = '0;
    logic          in_sym = 1'b0, in_len = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [W-1:0]  out_hi, out_lo;
    logic          out_sat;
    logic          sticky_clr = 1'b0;
    logic          sticky_ovf;

    always #4 clk = ~clk;   // 125 MHz

    fracmul_top #(.DATA_W(W)) dut_i (
        .clk, .rst, .in_valid, .in_ready, .in_a, .in_b, .in_sym, .in_len,
        .out_valid, .out_ready, .out_hi, .out_lo, .out_sat,
        .sticky_clr, .sticky_ovf
    );

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         sat;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    int    rdy_mode = 0;       // 0: always ready, 1: never, 2: pattern
    logic [31:0] rdy_lfsr = 32'h1;
    logic [31:0] seed = 32'h2468ACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic sym, input logic single);
        exp_t r;
        logic [W-1:0] ea, eb;
        logic [63:0]  p, n;
        ea = (sym && a == 32'h8000_0000) ? 32'h8000_0001 : a;
        eb = (sym && b == 32'h8000_0000) ? 32'h8000_0001 : b;
        p  = 64'($signed(longint'($signed(ea))) * $signed(longint'($signed(eb))));
        r.sat = 1'b0;
        if (p[63] != p[62]) begin
            n = 64'h7FFF_FFFF_FFFF_FFFF;
            r.sat = 1'b1;
        end else begin
            n = p << 1;
        end
        if (single) begin
            r.lo = '0;
            if (n[63:32] == 32'h7FFF_FFFF && n[31]) begin
                r.hi  = 32'h7FFF_FFFF;
                r.sat = 1'b1;
            end else begin
                r.hi = n[63:32] + {31'b0, n[31]};
            end
        end else begin
            r.hi = n[63:32];
            r.lo = n[31:0];
        end
        return r;
    endfunction

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic sym, input logic single, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_sym = sym; in_len = single;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        exp_q.push_back(model(a, b, sym, single));
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R8", "results missing after drain", 64'(exp_q.size()), 64'd0);
        repeat (2) @(negedge clk);
    endtask

    // Monitor / scoreboard
    logic          prev_stall = 1'b0;
    logic [W-1:0]  prev_hi, prev_lo;
    logic          prev_sat;
    initial begin
        forever begin
            @(negedge clk);
            rdy_lfsr  = {rdy_lfsr[30:0], rdy_lfsr[31] ^ rdy_lfsr[21] ^ rdy_lfsr[1] ^ rdy_lfsr[0]};
            out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : rdy_lfsr[3];
            #3;
            if (!rst) begin
                if (prev_stall) begin
                    // R8: stalled output must not move
                    check(out_valid && out_hi == prev_hi && out_lo == prev_lo && out_sat == prev_sat,
                          "R8", "stalled output changed",
                          {out_hi, out_lo}, {prev_hi, prev_lo});
                end
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected result", {out_hi, out_lo}, 64'd0);
                    end else begin
                        exp_t  e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({out_hi, out_lo} == {e.hi, e.lo}, t, "result word", {out_hi, out_lo}, {e.hi, e.lo});
                        check(out_sat == e.sat, "R4", "saturation bit", 64'(out_sat), 64'(e.sat));
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_hi = out_hi; prev_lo = out_lo; prev_sat = out_sat;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R9: state after reset
        check(!out_valid, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
        check(!sticky_ovf, "R9", "sticky after reset", 64'(sticky_ovf), 64'd0);
        check(in_ready, "R9", "in_ready after reset", 64'(in_ready), 64'd1);

        // R7: latency of an unstalled pair
        send(32'h4000_0000, 32'h4000_0000, 1'b0, 1'b0, "R1");
        @(negedge clk); #4;
        check(!out_valid, "R7", "valid one edge after accept", 64'(out_valid), 64'd0);
        @(negedge clk); #4;
        check(out_valid, "R7", "valid two edges after accept", 64'(out_valid), 64'd1);
        drain();

        // R1: ordinary double-length products
        send(32'h4000_0000, 32'hC000_0000, 1'b0, 1'b0, "R1");
        send(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0, "R1");
        send(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, "R1");
        send(32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1");
        send(32'h8000_0000, 32'h8000_0001, 1'b0, 1'b0, "R1");
        // R3: rounding cases in single length
        send(32'h0000_C000, 32'h0001_0000, 1'b0, 1'b1, "R3");
        send(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1, "R3");
        send(32'hC000_0001, 32'h4000_0001, 1'b0, 1'b1, "R3");
        drain();
        check(!sticky_ovf, "R5", "sticky without saturation", 64'(sticky_ovf), 64'd0);

        // R2: the split-sign pair in double length
        send(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R2");
        drain();
        check(sticky_ovf, "R5", "sticky after clamp", 64'(sticky_ovf), 64'd1);
        repeat (3) @(negedge clk);
        #4;
        check(sticky_ovf, "R5", "sticky held while idle", 64'(sticky_ovf), 64'd1);
        @(negedge clk); sticky_clr = 1'b1;
        @(negedge clk); sticky_clr = 1'b0;
        #4;
        check(!sticky_ovf, "R5", "sticky after clear", 64'(sticky_ovf), 64'd0);

        // R2: the split-sign pair in single length
        send(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R2");
        drain();
        check(sticky_ovf, "R5", "sticky after single clamp", 64'(sticky_ovf), 64'd1);
        @(negedge clk); sticky_clr = 1'b1;
        @(negedge clk); sticky_clr = 1'b0;

        // R6: symmetric range removes the clamp
        send(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R6");
        send(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, "R6");
        send(32'h8000_0000, 32'h4000_0000, 1'b1, 1'b0, "R6");
        drain();
        check(!sticky_ovf, "R6", "sticky in symmetric mode", 64'(sticky_ovf), 64'd0);

        // R10 / R8: full pipe under back-pressure
        rdy_mode = 1;
        send(32'h1234_5678, 32'h0ABC_DEF0, 1'b0, 1'b0, "R8");
        send(32'hF000_0000, 32'h3000_0000, 1'b0, 1'b1, "R8");
        @(negedge clk); #4;
        check(!in_ready, "R10", "in_ready with full pipe", 64'(in_ready), 64'd0);
        check(out_valid, "R10", "output held while full", 64'(out_valid), 64'd1);
        repeat (4) @(negedge clk);
        rdy_mode = 0;
        drain();

        // Mixed traffic with irregular back-pressure
        rdy_mode = 2;
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] a, b;
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223;
            b = seed;
            if (i % 7 == 3) begin a = 32'h8000_0000; b = 32'h8000_0000; end
            send(a, b, seed[5], seed[9], seed[9] ? "R3" : "R1");
        end
        rdy_mode = 0;
        drain();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule